// File: doc/BRIEF.md
# GPIO Controller with Sticky Event Detection

This block gives software control of up to 54 general-purpose pins through a word-addressed register bus. Every pin carries a 3-bit function field; only the plain-output code turns its output driver on. Output levels are never written directly. One register raises the selected pins and a second register lowers them, so two agents can change different pins without a read-modify-write race.

Pin inputs pass through a two-flop synchronizer. The synchronized levels can be read back, and they feed four detectors per pin: rising edge, falling edge, high level and low level. Each detector has its own enable bit. Any enabled detection sets a sticky status bit, which software clears by writing a one to it. Each 32-pin bank raises an interrupt line while any of its status bits is set.

A pull-control latch for each pin holds a 2-bit mode. It is loaded by a strobe sequence: write the mode, set the pins' bits in a per-bank pull-clock register, then write that register back to zero. Writes take effect at the clock edge on which `busWrEn` is sampled. Read data is combinational from `busAddr`. Bank 0 holds pins 0-31 in bits 0-31, and bank 1 holds pins 32-53 in bits 0-21.

Top module: `gpio_event_ctrl`

## Requirements
- R1: Function-select word k (address k, 0..5) holds pin n at word n/10, bits 3*(n%10)+2 : 3*(n%10). The word reads back what was written, and fields of nonexistent pins read 0. Every field resets to 0 (input).
- R2: `pinOe[n]` is 1 exactly when pin n's function field equals 1. Any other code, including alternates 4/5/6/7/3/2, leaves it 0.
- R3: Writing to the set register (address 6 for bank 0, 7 for bank 1) drives `pinOut` high for every 1 bit. Bits written as 0 leave their pins unchanged.
- R4: Writing to the clear register (address 8 for bank 0, 9 for bank 1) drives `pinOut` low for every 1 bit. Bits written as 0 leave their pins unchanged. Both registers read 0.
- R5: The level register (address 10 for bank 0, 11 for bank 1) returns `pinIn` as it stood two clock edges earlier.
- R6: With the rising-edge enable set (address 14/15), a 0-to-1 pin change sets the status bit (address 12/13) on the third clock edge after the change. With the enable clear, the change leaves the bit at 0.
- R7: With the falling-edge enable set (address 16/17), a 1-to-0 pin change sets the status bit. With the enable clear, the change leaves the bit at 0.
- R8: With the high-level enable set (address 18/19), a high pin sets the status bit. A clear written while the pin stays high leaves the bit set.
- R9: With the low-level enable set (address 20/21), a low pin sets the status bit.
- R10: Status bits are sticky and remain set after their condition ends. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: `irq[0]` is the OR of the bank 0 status bits, and `irq[1]` is the OR of the bank 1 status bits.
- R12: The pull-mode register (address 22, bits 1:0; 0 none, 1 down, 2 up) is copied into pin n's 2-bit `pinPull` field only when pin n's pull-clock bit (address 23/24) is written from 0 to 1. Writing the bit back to 0, or writing 1 to a bit that is already 1, leaves the field unchanged.
- R13: After reset, `pinOut`, `pinOe`, `pinPull` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Word address |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| pinIn | input | 54 | Pad input levels |
| pinOut | output | 54 | Output value per pin |
| pinOe | output | 54 | Output enable per pin |
| pinPull | output | 108 | Pull mode, 2 bits per pin (pin n at 2n+1:2n) |
| irq | output | 2 | Per-bank event interrupt |

## Verification
The bench targets the following corner cases:

- **Function-field layout.** Fields that straddle word boundaries, and the short final word, are checked. A mis-packed layout would enable the wrong pin's driver or read back stray bits.
- **Detection timing.** Edge timing is checked against the synchronizer depth, using random pin vectors and random enable masks. A design with a missing delay stage, or one that reports edges for disabled pins, produces wrong status words.
- **Clear racing a held level.** A clear that arrives while a high-level condition persists is checked. A design that lets the clear win would lose the event.
- **Pull-latch strobe.** The test writes a pull-clock bit of 1 while it is already 1. A design that loads on level rather than on the 0-to-1 transition would overwrite the latched mode.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_FSEL, K_SET, K_CLR, K_LEV, K_EDS,
    K_REN, K_FEN, K_HEN, K_LEN, K_PMODE, K_PCLK
  } regKind_e;

  // strobe bundle from bus control to datapath
  typedef struct packed {
    logic     wrStb;
    regKind_e kind;
    logic [2:0] idx;
  } busStrobe_t;

  localparam logic [2:0] FUNC_OUTPUT = 3'd1;
  localparam int BANK_W = 32;
  localparam int FIELDS_PER_WORD = 10;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_event_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_FSEL_REGS = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strb
);

  localparam int BASE_PAIR = NUM_FSEL_REGS;

  int unsigned addrI;
  int unsigned pairOff;

  always_comb begin
    addrI   = int'(busAddr);
    pairOff = 0;
    strb.kind = K_NONE;
    strb.idx  = '0;
    if (addrI < NUM_FSEL_REGS) begin
      strb.kind = K_FSEL;
      strb.idx  = 3'(addrI);
    end else begin
      pairOff  = addrI - BASE_PAIR;
      strb.idx = {2'b00, pairOff[0]};
      case (pairOff >> 1)
        0: strb.kind = K_SET;
        1: strb.kind = K_CLR;
        2: strb.kind = K_LEV;
        3: strb.kind = K_EDS;
        4: strb.kind = K_REN;
        5: strb.kind = K_FEN;
        6: strb.kind = K_HEN;
        7: strb.kind = K_LEN;
        8: begin
          strb.kind = pairOff[0] ? K_PCLK : K_PMODE;
          strb.idx  = '0;
        end
        9: if (!pairOff[0]) begin
          strb.kind = K_PCLK;
          strb.idx  = 3'd1;
        end
        default: strb.kind = K_NONE;
      endcase
    end
    strb.wrStb = busWrEn && (strb.kind != K_NONE);
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_event_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int NUM_FSEL_REGS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            strb,
  input  logic [BANK_W-1:0]     wdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [BANK_W-1:0]     rdata,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] pinPull,
  output logic [1:0]            irq
);

  localparam int VEC_W = 2 * BANK_W;
  localparam int FSEL_FIELDS = NUM_FSEL_REGS * FIELDS_PER_WORD;
  localparam logic [VEC_W-1:0] PIN_MASK =
    {{(VEC_W-NUM_PINS){1'b0}}, {NUM_PINS{1'b1}}};

  function automatic logic [VEC_W-1:0] placeLane(input logic [BANK_W-1:0] d, input logic bank);
    return bank ? {d, {BANK_W{1'b0}}} : {{BANK_W{1'b0}}, d};
  endfunction

  function automatic logic [BANK_W-1:0] pickLane(input logic [VEC_W-1:0] v, input logic bank);
    return bank ? v[VEC_W-1:BANK_W] : v[BANK_W-1:0];
  endfunction

  logic [VEC_W-1:0] outVal, renR, fenR, henR, lenR, eds, pclk;
  logic [VEC_W-1:0] syncA, syncB, prevB;
  logic [VEC_W-1:0] laneSel, wdPlaced, detect, edsClr, pclkRise;
  logic [1:0]       pmode;
  logic [2:0]       fsel [NUM_PINS];
  logic [1:0]       pull [NUM_PINS];
  logic [3*FSEL_FIELDS-1:0] fselFlat;
  logic             wrBank;

  assign wrBank   = strb.idx[0];
  assign laneSel  = placeLane({BANK_W{1'b1}}, wrBank);
  assign wdPlaced = placeLane(wdata, wrBank) & PIN_MASK;
  assign edsClr   = (strb.wrStb && strb.kind == K_EDS) ? wdPlaced : '0;
  assign pclkRise = (strb.wrStb && strb.kind == K_PCLK) ? (wdPlaced & ~pclk) : '0;

  assign detect = ((syncB & ~prevB & renR) | (~syncB & prevB & fenR) |
                   (syncB & henR) | (~syncB & lenR)) & PIN_MASK;

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVal <= '0; renR <= '0; fenR <= '0; henR <= '0; lenR <= '0;
      pclk <= '0; pmode <= '0;
    end else if (strb.wrStb) begin
      case (strb.kind)
        K_SET:   outVal <= outVal | wdPlaced;
        K_CLR:   outVal <= outVal & ~wdPlaced;
        K_REN:   renR   <= (renR & ~laneSel) | wdPlaced;
        K_FEN:   fenR   <= (fenR & ~laneSel) | wdPlaced;
        K_HEN:   henR   <= (henR & ~laneSel) | wdPlaced;
        K_LEN:   lenR   <= (lenR & ~laneSel) | wdPlaced;
        K_PCLK:  pclk   <= (pclk & ~laneSel) | wdPlaced;
        K_PMODE: pmode  <= wdata[1:0];
        default: ;
      endcase
    end
  end

  // synchronizer, edge history and sticky status (detection wins over clear)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0; eds <= '0;
    end else begin
      syncA <= {{(VEC_W-NUM_PINS){1'b0}}, pinIn};
      syncB <= syncA;
      prevB <= syncB;
      eds   <= (eds & ~edsClr) | detect;
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int WORD_I = p / FIELDS_PER_WORD;
      localparam int OFF_I  = 3 * (p % FIELDS_PER_WORD);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          fsel[p] <= '0;
          pull[p] <= '0;
        end else begin
          if (strb.wrStb && strb.kind == K_FSEL && int'(strb.idx) == WORD_I)
            fsel[p] <= wdata[OFF_I +: 3];
          if (pclkRise[p])
            pull[p] <= pmode;
        end
      end
      assign fselFlat[3*p +: 3]  = fsel[p];
      assign pinOe[p]            = (fsel[p] == FUNC_OUTPUT);
      assign pinPull[2*p +: 2]   = pull[p];
    end
    for (p = NUM_PINS; p < FSEL_FIELDS; p++) begin : g_fill
      assign fselFlat[3*p +: 3] = 3'b000;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (strb.kind)
      K_FSEL:  rdata = {2'b00, fselFlat[30*int'(strb.idx) +: 30]};
      K_LEV:   rdata = pickLane(syncB, wrBank);
      K_EDS:   rdata = pickLane(eds, wrBank);
      K_REN:   rdata = pickLane(renR, wrBank);
      K_FEN:   rdata = pickLane(fenR, wrBank);
      K_HEN:   rdata = pickLane(henR, wrBank);
      K_LEN:   rdata = pickLane(lenR, wrBank);
      K_PCLK:  rdata = pickLane(pclk, wrBank);
      K_PMODE: rdata = {30'd0, pmode};
      default: rdata = '0;
    endcase
  end

  assign pinOut = outVal[NUM_PINS-1:0];
  assign irq    = {|eds[VEC_W-1:BANK_W], |eds[BANK_W-1:0]};

  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.kind == K_SET) |=> ((outVal & $past(wdPlaced)) == $past(wdPlaced)));

  assert_clr_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.kind == K_CLR) |=> ((outVal & $past(wdPlaced)) == '0));

  assert_rise_caught_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((syncB & ~prevB & renR) != '0) |=> ((eds & $past(syncB & ~prevB & renR)) == $past(syncB & ~prevB & renR)));

  assert_eds_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrStb && strb.kind == K_EDS) |=> ((eds & $past(eds)) == $past(eds)));

  assert_pull_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrStb && strb.kind == K_PCLK) |=> $stable(pinPull));

endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
  import gpio_event_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] pinPull,
  output logic [1:0]            irq
);

  localparam int NUM_FSEL_REGS = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

  busStrobe_t strb;

  gpio_bus_ctrl #(.ADDR_W(ADDR_W), .NUM_FSEL_REGS(NUM_FSEL_REGS)) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS), .NUM_FSEL_REGS(NUM_FSEL_REGS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .pinIn(pinIn),
    .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .pinPull(pinPull), .irq(irq)
  );

endmodule

// File: tb/gpio_event_ctrl_tb_top.sv
module gpio_event_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;

  logic clk = 0;
  logic rstN = 0;
  logic [4:0] busAddr = '0;
  logic busWrEn = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [2*NP-1:0] pinPull;
  logic [1:0] irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_event_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pinPull(pinPull), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] fselMask(input int r);
    logic [31:0] m = '0;
    for (int k = 0; k < 10; k++) if (10*r + k < NP) m[3*k +: 3] = 3'b111;
    return m;
  endfunction

  function automatic logic [NP-1:0] expOe(input logic [31:0] w [6]);
    logic [NP-1:0] o = '0;
    for (int n = 0; n < NP; n++) o[n] = (w[n/10][3*(n%10) +: 3] == 3'd1);
    return o;
  endfunction

  function automatic logic [63:0] expEdges(input logic [63:0] oldV, newV, re, fe);
    return ((newV & ~oldV & re) | (~newV & oldV & fe)) & {10'd0, {NP{1'b1}}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d1;
    logic [31:0] fselM [6];
    logic [63:0] outM, oldP, newP, reM, feM, expE;
    logic [2*NP-1:0] pullM;
    void'($urandom(32'd20240611));

    settle(3);
    rstN = 1;
    settle(2);

    // R13 reset state
    chk("R13 pinOut", 128'(pinOut), 128'(0));
    chk("R13 pinOe", 128'(pinOe), 128'(0));
    chk("R13 pinPull", 128'(pinPull), 128'(0));
    chk("R13 irq", 128'(irq), 128'(0));
    for (int r = 0; r < 6; r++) begin
      rd(5'(r), d);
      chk("R1 fsel reset", 128'(d), 128'(0));
    end

    // R1 / R2 random function fields plus directed codes
    for (int it = 0; it < 6; it++) begin
      for (int r = 0; r < 6; r++) begin
        d = $urandom();
        if (it == 0) d = 32'h0924_9249;            // every field = 1
        if (it == 1) d = {2'b11, 30'h3FFF_FFFF};   // every field = 7 (alternate code)
        fselM[r] = d & fselMask(r);
        wr(5'(r), d);
      end
      for (int r = 0; r < 6; r++) begin
        rd(5'(r), d);
        chk("R1 fsel readback", 128'(d), 128'(fselM[r]));
      end
      chk("R2 pinOe", 128'(pinOe), 128'(expOe(fselM)));
    end

    // R3 / R4 random set and clear
    outM = '0;
    for (int it = 0; it < 30; it++) begin
      d = $urandom();
      case ($urandom_range(3))
        0: begin wr(5'd6, d); outM[31:0] |= d; end
        1: begin wr(5'd7, d); outM[63:32] |= (d & 32'h003F_FFFF); end
        2: begin wr(5'd8, d); outM[31:0] &= ~d; end
        default: begin wr(5'd9, d); outM[63:32] &= ~(d & 32'h003F_FFFF); end
      endcase
      chk((it % 2 == 0) ? "R3 set/clr pinOut" : "R4 set/clr pinOut", 128'(pinOut), 128'(outM[NP-1:0]));
    end
    wr(5'd6, 32'h0); chk("R3 zero set no effect", 128'(pinOut), 128'(outM[NP-1:0]));
    wr(5'd9, 32'h0); chk("R4 zero clear no effect", 128'(pinOut), 128'(outM[NP-1:0]));
    rd(5'd8, d); chk("R4 clear reads zero", 128'(d), 128'(0));

    // R5 level readback timing
    for (int it = 0; it < 6; it++) begin
      @(negedge clk);
      newP = {$urandom(), $urandom()} & {10'd0, {NP{1'b1}}};
      pinIn = newP[NP-1:0];
      repeat (2) @(posedge clk);
      @(negedge clk); busAddr = 5'd10; #1;
      chk("R5 level bank0", 128'(busRdata), 128'(newP[31:0]));
      busAddr = 5'd11; #1;
      chk("R5 level bank1", 128'(busRdata), 128'(newP[63:32]));
    end

    // R6 directed rising edge, with and without enable
    pinIn = '0; settle(4);
    wr(5'd12, 32'hFFFF_FFFF); wr(5'd13, 32'hFFFF_FFFF);
    wr(5'd14, 32'h0000_0020);          // rise enable pin 5 only
    @(negedge clk); pinIn[5] = 1; pinIn[6] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); busAddr = 5'd12; #1;
    chk("R6 no status before third edge", 128'(busRdata), 128'(0));
    @(negedge clk); #1;
    chk("R6 rise pin5 only", 128'(busRdata), 128'(32'h20));
    chk("R11 irq bank0", 128'(irq), 128'(2'b01));

    // R7 falling edge on pin 40 (bank1 bit 8)
    wr(5'd14, 32'h0);
    @(negedge clk); pinIn[40] = 1; settle(4);
    wr(5'd17, 32'h0000_0100);
    @(negedge clk); pinIn[40] = 0; settle(4);
    rd(5'd13, d);
    chk("R7 fall pin40", 128'(d), 128'(32'h100));
    chk("R11 irq both", 128'(irq), 128'(2'b11));
    wr(5'd17, 32'h0);

    // R10 sticky, write-0 no effect, partial clear
    wr(5'd12, 32'h0); rd(5'd12, d);
    chk("R10 zero write keeps", 128'(d), 128'(32'h20));
    wr(5'd13, 32'h100); rd(5'd13, d);
    chk("R10 W1C bank1", 128'(d), 128'(0));
    chk("R11 irq bank1 drops", 128'(irq), 128'(2'b01));
    wr(5'd12, 32'h20); rd(5'd12, d);
    chk("R10 W1C bank0", 128'(d), 128'(0));
    chk("R11 irq idle", 128'(irq), 128'(0));

    // R8 high level persists through a clear
    @(negedge clk); pinIn[3] = 1; settle(4);
    wr(5'd18, 32'h8); settle(2);
    rd(5'd12, d); chk("R8 high detect", 128'(d), 128'(32'h8));
    wr(5'd12, 32'h8); rd(5'd12, d);
    chk("R8 reasserts while high", 128'(d), 128'(32'h8));
    wr(5'd18, 32'h0); wr(5'd12, 32'h8); rd(5'd12, d);
    chk("R10 clears once disabled", 128'(d), 128'(0));

    // R9 low level on pin 50 (bank1 bit 18)
    wr(5'd21, 32'h0004_0000); settle(2);
    rd(5'd13, d); chk("R9 low detect pin50", 128'(d), 128'(32'h0004_0000));
    wr(5'd21, 32'h0); wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, d); chk("R9 cleared", 128'(d), 128'(0));

    // R6 / R7 random edges under random enable masks
    oldP = {10'd0, NP'(pinIn)};
    reM = {$urandom(), $urandom()} & {10'd0, {NP{1'b1}}};
    feM = {$urandom(), $urandom()} & {10'd0, {NP{1'b1}}};
    wr(5'd14, reM[31:0]); wr(5'd15, reM[63:32]);
    wr(5'd16, feM[31:0]); wr(5'd17, feM[63:32]);
    wr(5'd12, 32'hFFFF_FFFF); wr(5'd13, 32'hFFFF_FFFF);
    for (int it = 0; it < 20; it++) begin
      @(negedge clk);
      newP = {$urandom(), $urandom()} & {10'd0, {NP{1'b1}}};
      pinIn = newP[NP-1:0];
      settle(5);
      expE = expEdges(oldP, newP, reM, feM);
      rd(5'd12, d); rd(5'd13, d1);
      chk((it % 2 == 0) ? "R6 random edges" : "R7 random edges", 128'({d1, d}), 128'(expE));
      chk("R11 irq random", 128'(irq), 128'({|expE[63:32], |expE[31:0]}));
      wr(5'd12, 32'hFFFF_FFFF); wr(5'd13, 32'hFFFF_FFFF);
      oldP = newP;
    end

    // R12 pull latch strobe sequence
    pullM = '0;
    wr(5'd22, 32'd2); wr(5'd23, 32'h0000_C000); wr(5'd23, 32'h0);
    pullM[29:28] = 2'd2; pullM[31:30] = 2'd2;
    chk("R12 pull up pins 14,15", 128'(pinPull), 128'(pullM));
    wr(5'd22, 32'd1); wr(5'd24, 32'h1);
    pullM[65:64] = 2'd1;
    chk("R12 pull down pin 32", 128'(pinPull), 128'(pullM));
    wr(5'd22, 32'd0); wr(5'd24, 32'h1);
    chk("R12 bit already 1 no reload", 128'(pinPull), 128'(pullM));
    wr(5'd24, 32'h0);
    chk("R12 write back zero no effect", 128'(pinPull), 128'(pullM));
    wr(5'd22, 32'd1); wr(5'd23, 32'h0000_4000);
    pullM[29:28] = 2'd1;
    chk("R12 reload pin 14", 128'(pinPull), 128'(pullM));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule